// File: doc/BRIEF.md
# BCD Real-Time Calendar with Two-Stage Prescaler

This block keeps the time of day and the calendar date as packed BCD fields. It derives a once-per-second advance from its input clock through two cascaded dividers: a short divider feeding a long divider. Every advance moves the seconds forward, and a carry ripples into minutes, hours, the day of month, the month, a two-digit year and a weekday. Month lengths and leap years are handled. Hours always count in 24-hour form.

Software reaches the block through a small word-wide register port with four addresses: time, date, a mode/status word and the prescaler. To load new values, software raises an initialization request and waits for the block to acknowledge it. While the request is up the counters stand still, and only then do writes to the time, date and prescaler words take effect. A resync flag, which software clears, tells it when the visible calendar words are settled again. A one-cycle pulse marks each calendar advance.

Top module: `bcd_cal`

## Requirements
- R1: After reset the time reads 00:00:00 and the date reads day 01, month 01, year 00, weekday 1. Request and acknowledge read 0, and the prescaler reads short divider 127 and long divider 255.
- R2: Address 0 returns the time as packed BCD: seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16. All other bits read 0.
- R3: Address 1 returns the date as packed BCD: day of month in bits 5:0, month in bits 12:8, weekday in bits 15:13 (1 = Monday up to 7 = Sunday), year in bits 23:16.
- R4: At address 2, bit 0 is the initialization request, written directly. Bit 1 is the acknowledge. It rises on the second clock edge after the edge that set the request. It falls on the first edge after the edge that cleared the request. The calendar and both dividers hold still while the request is set.
- R5: Writes to address 0, 1 and 3 take effect only while request and acknowledge are both set. At any other time they are ignored.
- R6: Address 3 holds the long divider S in bits 14:0 and the short divider A in bits 22:16. After the request is cleared, the calendar first advances (A+1)*(S+1) cycles after the clearing edge, and then every (A+1)*(S+1) cycles. The output sec_tick is high for exactly the cycle that follows each advance.
- R7: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day. Every digit stays valid BCD.
- R8: The day wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, February has 29 days when the BCD year is divisible by 4 (00 included) and 28 otherwise, and all other months have 31. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R9: The weekday advances on every day carry, and 7 wraps to 1.
- R10: Bit 2 of address 2 is the resync flag. Writing 0 to it clears it, and writing 1 has no effect. It is held clear while the request is set. Otherwise it returns to 1 on the second clock edge after it was cleared.
- R11: Bit 3 of address 2 reads 1 exactly when the year field is not 00.
- R12: Bit 4 of address 2 is the hour-format select. It always reads 0, writes to it are ignored, and the hours keep counting in 24-hour form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calendar clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word address: 0 time, 1 date, 2 mode/status, 3 prescaler |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| sec_tick | output | 1 | One-cycle pulse after each calendar advance |

## Verification
The digit-range properties depend on software loading only legal BCD values: seconds and minutes up to 59, hours up to 23, and a day that exists in its month. The block makes no attempt to repair an illegal load. Every value the stimulus writes is produced by a binary-to-BCD conversion of an in-range number, so the stimulus stays within that limit. The stall property also depends on no time write arriving in the cycle being observed. The sweeps use dividers of 0 so the calendar advances every cycle, which lets every month end of two years and February of all hundred years be reached in a short run.

// File: rtl/bcd_cal.sv
module bcd_cal #(
  parameter int A_W    = 7,
  parameter int S_W    = 15,
  parameter int A_INIT = 127,
  parameter int S_INIT = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sec_tick
);
  localparam logic [A_W-1:0] A_RST = A_W'(A_INIT);
  localparam logic [S_W-1:0] S_RST = S_W'(S_INIT);

  logic [7:0] sec, min, hr, day, mon, yr, last_day;
  logic [2:0] wd;
  logic [A_W-1:0] pre_a, cnt_a;
  logic [S_W-1:0] pre_s, cnt_s;
  logic init_req, req_q, init_ack, sync_flag, sync_w;
  logic wr_ok, wr_mode, adv, leap, cal_valid;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;
  logic unused_wdata;

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  assign unused_wdata = ^bus_wdata;
  assign wr_ok   = init_req && init_ack;
  assign wr_mode = bus_we && bus_addr == 2'd2;
  assign adv     = !init_req && cnt_a == pre_a && cnt_s == pre_s;
  assign cal_valid = yr != 8'h00;

  assign leap = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                      : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign s_wrap  = sec == 8'h59;
  assign m_wrap  = min == 8'h59;
  assign h_wrap  = hr  == 8'h23;
  assign d_wrap  = day == last_day;
  assign mo_wrap = mon == 8'h12;
  assign y_wrap  = yr  == 8'h99;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hr <= 8'h00;
      day <= 8'h01; mon <= 8'h01; yr <= 8'h00; wd <= 3'd1;
    end else if (bus_we && wr_ok && bus_addr == 2'd0) begin
      sec <= {1'b0, bus_wdata[6:0]};
      min <= {1'b0, bus_wdata[14:8]};
      hr  <= {2'b0, bus_wdata[21:16]};
    end else if (bus_we && wr_ok && bus_addr == 2'd1) begin
      day <= {2'b0, bus_wdata[5:0]};
      mon <= {3'b0, bus_wdata[12:8]};
      wd  <= bus_wdata[15:13];
      yr  <= bus_wdata[23:16];
    end else if (adv) begin
      sec <= s_wrap ? 8'h00 : bcd_up(sec);
      if (s_wrap) min <= m_wrap ? 8'h00 : bcd_up(min);
      if (s_wrap && m_wrap) hr <= h_wrap ? 8'h00 : bcd_up(hr);
      if (s_wrap && m_wrap && h_wrap) begin
        day <= d_wrap ? 8'h01 : bcd_up(day);
        wd  <= (wd == 3'd7) ? 3'd1 : wd + 3'd1;
        if (d_wrap) begin
          mon <= mo_wrap ? 8'h01 : bcd_up(mon);
          if (mo_wrap) yr <= y_wrap ? 8'h00 : bcd_up(yr);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_a <= A_RST; pre_s <= S_RST;
      cnt_a <= '0;    cnt_s <= '0;
    end else begin
      if (bus_we && wr_ok && bus_addr == 2'd3) begin
        pre_s <= bus_wdata[S_W-1:0];
        pre_a <= bus_wdata[16 +: A_W];
      end
      if (init_req) begin
        cnt_a <= '0;
        cnt_s <= '0;
      end else if (cnt_a == pre_a) begin
        cnt_a <= '0;
        cnt_s <= (cnt_s == pre_s) ? '0 : cnt_s + S_W'(1);
      end else begin
        cnt_a <= cnt_a + A_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_req <= 1'b0; req_q <= 1'b0; init_ack <= 1'b0;
      sync_flag <= 1'b0; sync_w <= 1'b0; sec_tick <= 1'b0;
    end else begin
      if (wr_mode) init_req <= bus_wdata[0];
      req_q    <= init_req;
      init_ack <= req_q && init_req;
      sec_tick <= adv;
      if (init_req || (wr_mode && !bus_wdata[2])) begin
        sync_flag <= 1'b0;
        sync_w    <= 1'b0;
      end else if (!sync_flag) begin
        sync_w    <= 1'b1;
        sync_flag <= sync_w;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = {10'b0, hr[5:0], 1'b0, min[6:0], 1'b0, sec[6:0]};
      2'd1: bus_rdata = {8'b0, yr, wd, mon[4:0], 2'b0, day[5:0]};
      2'd2: bus_rdata = {27'b0, 1'b0, cal_valid, sync_flag, init_ack, init_req};
      default: begin
        bus_rdata[S_W-1:0]  = pre_s;
        bus_rdata[16 +: A_W] = pre_a;
      end
    endcase
  end
endmodule

// File: rtl/bcd_cal_chk.sv
module bcd_cal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       init_ack,
  input logic       sync_flag,
  input logic       sec_tick,
  input logic [7:0] sec,
  input logic [7:0] hr,
  input logic       bus_we,
  input logic [1:0] bus_addr
);
  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> $past(init_req));

  assert_ack_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req |=> !init_ack);

  assert_frozen_in_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !(bus_we && bus_addr == 2'd0)) |=> $stable(sec));

  assert_tick_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (sec != $past(sec)));

  assert_sec_bcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'h9) && (sec[7:4] <= 4'h5));

  assert_hour_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hr[3:0] <= 4'h9) && (hr <= 8'h23));

  assert_sync_low_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !sync_flag);
endmodule

bind bcd_cal bcd_cal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .sync_flag(sync_flag), .sec_tick(sec_tick), .sec(sec), .hr(hr),
  .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/sim_bcd_cal.sv
module sim_bcd_cal;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, sec_tick;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  int total = 0, bad = 0;
  int ms, mm, mh, md, mmo, my, mw;

  bcd_cal u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
              .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] tob(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] pk_time(int h, int m, int s);
    return (32'(tob(h)) << 16) | (32'(tob(m)) << 8) | 32'(tob(s));
  endfunction

  function automatic logic [31:0] pk_date(int d, int mo, int y, int w);
    return (32'(tob(y)) << 16) | (32'(w) << 13) | (32'(tob(mo)) << 8) | 32'(tob(d));
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d, input logic [31:0] p);
    wr(2'd2, 32'h1);
    repeat (2) @(negedge clk);
    wr(2'd0, t);
    wr(2'd1, d);
    wr(2'd3, p);
    wr(2'd2, 32'h0);
  endtask

  task automatic model_tick();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; md++;
          mw = (mw == 7) ? 1 : mw + 1;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic one_step(input string r);
    load(pk_time(mh, mm, ms), pk_date(md, mmo, my, mw), 32'h0);
    @(negedge clk);
    model_tick();
    rd(2'd1, rv); chk(r, rv, pk_date(md, mmo, my, mw));
    rd(2'd0, rv); chk(r, rv, pk_time(mh, mm, ms));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R6 watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, rv); chk("R1 time", rv, 32'h0);
    rd(2'd1, rv); chk("R1 date", rv, pk_date(1, 1, 0, 1));
    rd(2'd3, rv); chk("R1 prescaler", rv, (32'd127 << 16) | 32'd255);
    rd(2'd2, rv); chk("R1 R11 mode req/ack/valid", rv & 32'hB, 32'h0);
    repeat (3) @(negedge clk);
    rd(2'd2, rv); chk("R10 sync set after reset", rv & 32'h4, 32'h4);

    wr(2'd0, 32'h00123456); rd(2'd0, rv); chk("R5 time write ignored", rv, 32'h0);
    wr(2'd1, 32'h00254321); rd(2'd1, rv); chk("R5 date write ignored", rv, pk_date(1, 1, 0, 1));
    wr(2'd3, 32'h00010002); rd(2'd3, rv); chk("R5 prescaler write ignored", rv, (32'd127 << 16) | 32'd255);

    wr(2'd2, 32'h10);
    rd(2'd2, rv); chk("R12 format bit reads 0", rv & 32'h10, 32'h0);
    chk("R10 sync cleared by write", rv & 32'h4, 32'h0);
    @(negedge clk); rd(2'd2, rv); chk("R10 sync still low", rv & 32'h4, 32'h0);
    @(negedge clk); rd(2'd2, rv); chk("R10 sync back high", rv & 32'h4, 32'h4);

    wr(2'd2, 32'h5);
    rd(2'd2, rv); chk("R4 ack low after 1 edge", rv & 32'h3, 32'h1);
    @(negedge clk); rd(2'd2, rv); chk("R4 ack low after 2nd edge pending", rv & 32'h3, 32'h1);
    chk("R10 sync held low in init", rv & 32'h4, 32'h0);
    @(negedge clk); rd(2'd2, rv); chk("R4 ack high", rv & 32'h3, 32'h3);
    wr(2'd0, pk_time(13, 45, 10));
    wr(2'd1, pk_date(15, 6, 23, 4));
    wr(2'd3, (32'd1 << 16) | 32'd2);
    rd(2'd0, rv); chk("R2 time loaded", rv, pk_time(13, 45, 10));
    rd(2'd1, rv); chk("R3 date loaded", rv, pk_date(15, 6, 23, 4));
    rd(2'd3, rv); chk("R6 prescaler loaded", rv, (32'd1 << 16) | 32'd2);
    rd(2'd2, rv); chk("R11 valid for year 23", rv & 32'h8, 32'h8);
    repeat (10) @(negedge clk);
    rd(2'd0, rv); chk("R4 frozen while request set", rv, pk_time(13, 45, 10));
    wr(2'd2, 32'h0);
    rd(2'd2, rv); chk("R4 ack still up one cycle", rv & 32'h3, 32'h2);
    for (int k = 1; k <= 2; k++) begin
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (!sec_tick && n < 50);
      chk("R6 tick period", 32'(n), (k == 1) ? 32'd6 : 32'd6);
      rd(2'd0, rv); chk("R6 R7 second advanced", rv, pk_time(13, 45, 10 + k));
    end
    @(negedge clk);
    chk("R6 tick one cycle wide", {31'b0, sec_tick}, 32'h0);

    for (int y = 23; y <= 24; y++)
      for (int m = 1; m <= 12; m++) begin
        mh = 23; mm = 59; ms = 59; md = dim(m, y); mmo = m; my = y; mw = (m % 7) + 1;
        one_step("R8 R9 month end");
      end
    for (int y = 0; y < 100; y++) begin
      mh = 23; mm = 59; ms = 59; md = 28; mmo = 2; my = y; mw = 7;
      one_step("R8 R9 february 28");
      mh = 23; mm = 59; ms = 59; md = dim(2, y); mmo = 2; my = y; mw = 3;
      one_step("R8 february last day");
    end

    mh = 23; mm = 58; ms = 0; md = 31; mmo = 12; my = 99; mw = 7;
    load(pk_time(mh, mm, ms), pk_date(md, mmo, my, mw), 32'h0);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      model_tick();
      rd(2'd0, rv); chk("R7 continuous time", rv, pk_time(mh, mm, ms));
    end
    rd(2'd1, rv); chk("R8 R9 year wrap", rv, pk_date(1, 1, 0, 1));
    rd(2'd2, rv); chk("R11 not valid at year 00", rv & 32'h8, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule